// File: doc/BRIEF.md
# I2C Master Bus Command Engine

This block is the bus-level engine of a register-driven I2C master. Software sets a timing word, opens the pad drivers, and then issues one operation at a time: a START, a repeated START, a STOP, or the transmission of a single byte followed by the target's acknowledge bit. The engine drives an open-drain SCL/SDA pair through two "pull low" outputs. It reports the end of each operation in a sticky status word. It also records whether the addressed target answered the last byte with a NAK.

The command register packs the enable, a two-bit operation code and a mode bit. On a write, that mode bit picks a plain START or a repeated START. On a read, the same bit position returns the NAK flag of the last byte. All bus timing comes from a quarter-bit phase. The phase length is the product of a prescaler, an optional post-divider and a phase multiplier, so the same engine covers 100 kHz, 400 kHz and 1 MHz buses from a wide range of core clocks.

Top module: `i2cm_core`

## Requirements
- R1: After reset the command register reads 0, the status register reads 0, `pad_oe_n` is 1 and both pull outputs are 0.
- R2: Writing the command register with enable (bit 0) = 1, operation field (bits 2:1) = 1 and mode bit (bit 3) = 0 while idle produces a START: SDA falls while SCL is high, and both lines end pulled low.
- R3: The same write with bit 3 = 1 produces a repeated START. SDA is released while SCL is low, SCL is then released, and SDA falls while SCL is high.
- R4: Operation field = 2 produces a STOP. SDA rises while SCL is high, and both lines are left released.
- R5: Writing the data register (index 2) while enabled and idle sends bits 7:0 MSB first. SDA changes only while SCL is low. A ninth clock follows with SDA released, and the acknowledge is sampled during that clock's high phase.
- R6: After a byte, bit 3 of the command register reads 1 if SDA was high at the acknowledge sample (NAK) and 0 if it was low.
- R7: Status (index 3) has these live bits: 7 rejected request, 3 operation done, 2 error, 1 byte sent, and 0 NAK; bit 0 is set only with bit 1. The bits are sticky and cleared by writing 1. Every other bit reads 0.
- R8: A request is ignored while enable is 0. A request made while an operation is running is also ignored, and it sets status bit 7.
- R9: Operation field = 3 starts no bus activity and sets status bit 2.
- R10: The timing word (index 1) holds the prescale in bits 8:6, the multiplier P in bits 5:3, the divider bypass in bit 2 and the divider in bits 1:0. One phase lasts (prescale+1)·(bypass ? 1 : divider+1)·(P+1) clocks. A condition takes 4 phases and a byte takes 36 phases. Status bit 3 appears one clock after the last phase.
- R11: Bit 2 of the pad register (index 4) drives `pad_oe_n`; it resets to 1. While it is 1, both pull outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 command, 1 timing, 2 data, 3 status, 4 pad |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| sda_in | input | 1 | Level sensed on the SDA line |
| scl_pull_o | output | 1 | 1 pulls SCL low |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| pad_oe_n | output | 1 | Active-low pad driver enable |

## Verification
Each result falls due on a fixed edge. A request is taken on the write edge, and the engine steps one phase every L clocks, where L is the product given in R10. Status bit 3 is therefore first visible 4L+1 edges after the write for a condition and 36L+1 edges after it for a byte. The bench counts edges from the write and samples status on the falling clock edge after each rising edge, so its count equals that edge number exactly. The bus-shape results (start and stop detection, the captured byte, the NAK flag) are all settled by the last phase. They are read only after the done bit has been seen.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_COND = 2'd1,
      CMD_STOP = 2'd2,
      CMD_RSVD = 2'd3
   } cmd_e;

   typedef enum logic [2:0] {
      OP_IDLE    = 3'd0,
      OP_START   = 3'd1,
      OP_RESTART = 3'd2,
      OP_STOP    = 3'd3,
      OP_BYTE    = 3'd4
   } op_e;

   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] RA_CMD    = 3'd0;
   localparam logic [ADDR_W-1:0] RA_TIMING = 3'd1;
   localparam logic [ADDR_W-1:0] RA_DATA   = 3'd2;
   localparam logic [ADDR_W-1:0] RA_STATUS = 3'd3;
   localparam logic [ADDR_W-1:0] RA_PAD    = 3'd4;

   localparam int CB_EN   = 0;
   localparam int CB_OP   = 1;
   localparam int CB_MODE = 3;

   localparam int SB_NAK    = 0;
   localparam int SB_SENT   = 1;
   localparam int SB_ERR    = 2;
   localparam int SB_DONE   = 3;
   localparam int SB_REJECT = 7;

   localparam int PB_OFF = 2;
endpackage

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
   parameter int PRE_W       = 3,
   parameter int P_W         = 3,
   parameter int DIV_W       = 2,
   parameter bit HAS_POSTDIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] pre,
   input  logic [P_W-1:0]   mult,
   input  logic [DIV_W-1:0] div,
   input  logic             bypass,
   output logic             tick
);
   logic [PRE_W-1:0] pre_cnt;
   logic [P_W-1:0]   mult_cnt;
   logic             pre_hit;
   logic             div_hit;

   assign pre_hit = (pre_cnt == pre);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pre_cnt <= '0;
      else if (!run)     pre_cnt <= '0;
      else if (pre_hit)  pre_cnt <= '0;
      else               pre_cnt <= pre_cnt + 1'b1;
   end

   generate
      if (HAS_POSTDIV) begin : g_postdiv
         logic [DIV_W-1:0] div_cnt;
         logic [DIV_W-1:0] div_lim;
         assign div_lim = bypass ? '0 : div;
         assign div_hit = pre_hit && (div_cnt == div_lim);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        div_cnt <= '0;
            else if (!run)     div_cnt <= '0;
            else if (div_hit)  div_cnt <= '0;
            else if (pre_hit)  div_cnt <= div_cnt + 1'b1;
         end
      end else begin : g_nodiv
         logic div_unused;
         assign div_unused = ^{div, bypass};
         assign div_hit = pre_hit;
      end
   endgenerate

   assign tick = div_hit && (mult_cnt == mult);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mult_cnt <= '0;
      else if (!run)     mult_cnt <= '0;
      else if (tick)     mult_cnt <= '0;
      else if (div_hit)  mult_cnt <= mult_cnt + 1'b1;
   end
endmodule

// File: rtl/i2cm_bus_engine.sv
module i2cm_bus_engine
   import i2cm_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              go,
   input  op_e               go_op,
   input  logic [BYTE_W-1:0] go_byte,
   input  logic              sda_in,
   output logic              busy,
   output op_e               op,
   output logic              done,
   output logic              done_byte,
   output logic              nak,
   output logic              scl_pull,
   output logic              sda_pull
);
   localparam int BIT_W = $clog2(BYTE_W + 1);
   localparam logic [BIT_W-1:0] ACK_IDX = BIT_W'(BYTE_W);

   op_e               op_q;
   logic [1:0]        ph_q;
   logic [BIT_W-1:0]  bit_q;
   logic [BYTE_W-1:0] sh_q;
   logic              last_step;

   assign busy = (op_q != OP_IDLE);
   assign op   = op_q;
   assign last_step = (ph_q == 2'd3) && ((op_q != OP_BYTE) || (bit_q == ACK_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q      <= OP_IDLE;
         ph_q      <= '0;
         bit_q     <= '0;
         sh_q      <= '0;
         scl_pull  <= 1'b0;
         sda_pull  <= 1'b0;
         nak       <= 1'b0;
         done      <= 1'b0;
         done_byte <= 1'b0;
      end else begin
         done      <= 1'b0;
         done_byte <= 1'b0;
         if (go && !busy) begin
            op_q  <= go_op;
            ph_q  <= '0;
            bit_q <= '0;
            sh_q  <= go_byte;
         end else if (busy && tick) begin
            unique case (op_q)
               OP_START: begin
                  case (ph_q)
                     2'd0: begin sda_pull <= 1'b0; scl_pull <= 1'b0; end
                     2'd1: sda_pull <= 1'b1;
                     2'd2: scl_pull <= 1'b1;
                     default: ;
                  endcase
               end
               OP_RESTART: begin
                  case (ph_q)
                     2'd0: sda_pull <= 1'b0;
                     2'd1: scl_pull <= 1'b0;
                     2'd2: sda_pull <= 1'b1;
                     default: scl_pull <= 1'b1;
                  endcase
               end
               OP_STOP: begin
                  case (ph_q)
                     2'd0: sda_pull <= 1'b1;
                     2'd1: scl_pull <= 1'b0;
                     2'd2: sda_pull <= 1'b0;
                     default: ;
                  endcase
               end
               OP_BYTE: begin
                  case (ph_q)
                     2'd0: begin
                        scl_pull <= 1'b1;
                        sda_pull <= (bit_q < ACK_IDX) ? ~sh_q[BYTE_W-1] : 1'b0;
                     end
                     2'd1: scl_pull <= 1'b0;
                     2'd2: if (bit_q == ACK_IDX) nak <= sda_in;
                     default: begin
                        scl_pull <= 1'b1;
                        sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
                        bit_q    <= bit_q + 1'b1;
                     end
                  endcase
               end
               default: ;
            endcase
            ph_q <= ph_q + 1'b1;
            if (last_step) begin
               op_q      <= OP_IDLE;
               done      <= 1'b1;
               done_byte <= (op_q == OP_BYTE);
            end
         end
      end
   end
endmodule

// File: rtl/i2cm_core.sv
module i2cm_core
   import i2cm_pkg::*;
#(
   parameter int REG_W       = 32,
   parameter int PRE_W       = 3,
   parameter int P_W         = 3,
   parameter int DIV_W       = 2,
   parameter bit HAS_POSTDIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              sda_in,
   output logic              scl_pull_o,
   output logic              sda_pull_o,
   output logic              pad_oe_n
);
   localparam int BYTE_W  = 8;
   localparam int DIV_LSB = 0;
   localparam int BYP_BIT = DIV_W;
   localparam int P_LSB   = DIV_W + 1;
   localparam int PRE_LSB = P_LSB + P_W;
   localparam int TIM_W   = PRE_LSB + PRE_W;

   generate
      if (PRE_W < 1 || P_W < 1 || DIV_W < 1) begin : g_bad_field
         $error("i2cm_core: timing fields need at least one bit each");
      end
      if (TIM_W > REG_W || REG_W < 16) begin : g_bad_reg
         $error("i2cm_core: register width too small for the timing word");
      end
   endgenerate

   logic                 ctrl_en_q;
   cmd_e                 ctrl_cmd_q;
   logic [TIM_W-1:0]     timing_q;
   logic [BYTE_W-1:0]    data_q;
   logic [7:0]           stat_q;
   logic                 pad_off_q;

   logic                 wr_cmd, wr_data, wr_stat;
   cmd_e                 new_cmd;
   logic                 new_en;
   logic                 cmd_req, byte_req, any_req;
   logic                 eng_go, reject, err_req;
   op_e                  go_op;
   logic                 eng_busy, eng_done, eng_done_byte, eng_nak;
   logic                 eng_scl, eng_sda, tick;
   op_e                  eng_op;
   logic [7:0]           st_set, st_clr;
   logic                 wdata_unused;

   assign wdata_unused = ^reg_wdata[REG_W-1:TIM_W];

   assign wr_cmd   = reg_wr && (reg_addr == RA_CMD);
   assign wr_data  = reg_wr && (reg_addr == RA_DATA);
   assign wr_stat  = reg_wr && (reg_addr == RA_STATUS);
   assign new_cmd  = cmd_e'(reg_wdata[CB_OP +: 2]);
   assign new_en   = reg_wdata[CB_EN];

   assign cmd_req  = wr_cmd && new_en && (new_cmd == CMD_COND || new_cmd == CMD_STOP);
   assign byte_req = wr_data && ctrl_en_q;
   assign any_req  = cmd_req || byte_req;
   assign eng_go   = any_req && !eng_busy;
   assign reject   = any_req && eng_busy;
   assign err_req  = wr_cmd && new_en && (new_cmd == CMD_RSVD);

   always_comb begin
      if (byte_req)                  go_op = OP_BYTE;
      else if (new_cmd == CMD_STOP)  go_op = OP_STOP;
      else if (reg_wdata[CB_MODE])   go_op = OP_RESTART;
      else                           go_op = OP_START;
   end

   always_comb begin
      st_set            = '0;
      st_set[SB_DONE]   = eng_done;
      st_set[SB_SENT]   = eng_done_byte;
      st_set[SB_NAK]    = eng_done_byte && eng_nak;
      st_set[SB_ERR]    = err_req;
      st_set[SB_REJECT] = reject;
      st_clr            = wr_stat ? reg_wdata[7:0] : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en_q  <= 1'b0;
         ctrl_cmd_q <= CMD_NONE;
         timing_q   <= '0;
         data_q     <= '0;
         stat_q     <= '0;
         pad_off_q  <= 1'b1;
      end else begin
         if (wr_cmd) begin
            ctrl_en_q  <= new_en;
            ctrl_cmd_q <= new_cmd;
         end
         if (reg_wr && reg_addr == RA_TIMING) timing_q <= reg_wdata[TIM_W-1:0];
         if (wr_data)                         data_q   <= reg_wdata[BYTE_W-1:0];
         if (reg_wr && reg_addr == RA_PAD)    pad_off_q <= reg_wdata[PB_OFF];
         stat_q <= (stat_q & ~st_clr) | st_set;
      end
   end

   i2cm_phase_timer #(
      .PRE_W(PRE_W), .P_W(P_W), .DIV_W(DIV_W), .HAS_POSTDIV(HAS_POSTDIV)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (eng_busy),
      .pre    (timing_q[PRE_LSB +: PRE_W]),
      .mult   (timing_q[P_LSB +: P_W]),
      .div    (timing_q[DIV_LSB +: DIV_W]),
      .bypass (timing_q[BYP_BIT]),
      .tick   (tick)
   );

   i2cm_bus_engine #(.BYTE_W(BYTE_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .go        (eng_go),
      .go_op     (go_op),
      .go_byte   (reg_wdata[BYTE_W-1:0]),
      .sda_in    (sda_in),
      .busy      (eng_busy),
      .op        (eng_op),
      .done      (eng_done),
      .done_byte (eng_done_byte),
      .nak       (eng_nak),
      .scl_pull  (eng_scl),
      .sda_pull  (eng_sda)
   );

   assign scl_pull_o = eng_scl && !pad_off_q;
   assign sda_pull_o = eng_sda && !pad_off_q;
   assign pad_oe_n   = pad_off_q;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_CMD: begin
            reg_rdata[CB_EN]      = ctrl_en_q;
            reg_rdata[CB_OP +: 2] = ctrl_cmd_q;
            reg_rdata[CB_MODE]    = eng_nak;
         end
         RA_TIMING: reg_rdata[TIM_W-1:0]  = timing_q;
         RA_DATA:   reg_rdata[BYTE_W-1:0] = data_q;
         RA_STATUS: reg_rdata[7:0]        = stat_q;
         RA_PAD:    reg_rdata[PB_OFF]     = pad_off_q;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/i2cm_core_chk.sv
module i2cm_core_chk
   import i2cm_pkg::*;
#(
   parameter int REG_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              go,
   input logic              done,
   input logic [2:0]        op,
   input logic              scl_pull,
   input logic              sda_pull,
   input logic              pad_off,
   input logic              scl_pull_o,
   input logic              sda_pull_o,
   input logic              ctrl_en,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [REG_W-1:0]  reg_rdata
);
   assert_sda_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_BYTE && $past(op == OP_BYTE) && !scl_pull && $past(!scl_pull))
      |-> $stable(sda_pull));

   assert_no_start_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !busy);

   assert_start_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ctrl_en);

   assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   assert_stop_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $past(op == OP_STOP)) |-> (!scl_pull && !sda_pull));

   assert_pad_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pad_off |-> (!scl_pull_o && !sda_pull_o));

   assert_status_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RA_STATUS) |-> ((reg_rdata & 32'hFFFF_FF70) == 32'h0));
endmodule

bind i2cm_core i2cm_core_chk #(.REG_W(REG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (eng_busy),
   .go         (eng_go),
   .done       (eng_done),
   .op         (eng_op),
   .scl_pull   (eng_scl),
   .sda_pull   (eng_sda),
   .pad_off    (pad_off_q),
   .scl_pull_o (scl_pull_o),
   .sda_pull_o (sda_pull_o),
   .ctrl_en    (ctrl_en_q),
   .reg_addr   (reg_addr),
   .reg_rdata  (reg_rdata)
);

// File: tb/i2cm_core_bench.sv
`timescale 1ns/1ps
module i2cm_core_bench;
   localparam logic [2:0] A_CMD = 3'd0, A_TIM = 3'd1, A_DATA = 3'd2, A_STAT = 3'd3, A_PAD = 3'd4;
   localparam logic [1:0] K_START = 2'd0, K_RESTART = 2'd1, K_STOP = 2'd2, K_BYTE = 2'd3;
   localparam int NV = 8;
   // entry: {timing[8:0], kind[1:0], byte[7:0], target_nak}
   localparam logic [19:0] VEC [NV] = '{
      {9'h000, K_START,   8'h00, 1'b0},
      {9'h000, K_BYTE,    8'hA5, 1'b0},
      {9'h041, K_BYTE,    8'h3C, 1'b1},
      {9'h017, K_RESTART, 8'h00, 1'b0},
      {9'h017, K_BYTE,    8'h81, 1'b0},
      {9'h088, K_BYTE,    8'h00, 1'b0},
      {9'h000, K_STOP,    8'h00, 1'b0},
      {9'h000, K_START,   8'h00, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        scl_pull_o, sda_pull_o, pad_oe_n;
   logic        tgt_pull = 1'b0;
   logic        tgt_nak = 1'b0;
   wire         scl_line = ~scl_pull_o;
   wire         sda_line = ~(sda_pull_o | tgt_pull);

   int errors = 0;
   int checks = 0;
   int starts = 0;
   int stops = 0;
   int bitcnt = 0;
   logic [7:0] shreg = '0;
   logic [7:0] captured = '0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   i2cm_core u_i2cm_core (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_line),
      .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .pad_oe_n(pad_oe_n)
   );

   // bus target model
   always @(negedge sda_line) if (scl_line) begin starts++; bitcnt = 0; end
   always @(posedge sda_line) if (scl_line) stops++;
   always @(posedge scl_line) begin
      if (bitcnt < 8) shreg = {shreg[6:0], sda_line};
      bitcnt++;
   end
   always @(negedge scl_line) begin
      if (bitcnt == 8) tgt_pull = !tgt_nak;
      else if (bitcnt == 9) begin tgt_pull = 1'b0; bitcnt = 0; captured = shreg; end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_done(output int n);
      logic [31:0] s;
      n = 0; s = '0;
      while (!s[3] && n < 4000) begin
         @(posedge clk); n++;
         @(negedge clk); rd(A_STAT, s);
      end
      if (!s[3]) begin
         checks++; errors++;
         $display("FAIL R10 watchdog actual=%0d expected=done", n);
      end
   endtask

   function automatic int phase_len(input logic [8:0] t);
      int div;
      div = t[2] ? 1 : (int'(t[1:0]) + 1);
      return (int'(t[8:6]) + 1) * div * (int'(t[5:3]) + 1);
   endfunction

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      int n, s0, p0, len;
      logic [8:0] tim;
      logic [1:0] kind;
      logic [7:0] byt;
      logic       nk;
      bit         quiet;

      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state
      rd(A_CMD, r);  chk("R1 command", r, 32'h0);
      rd(A_STAT, r); chk("R1 status", r, 32'h0);
      chk("R1 pad_oe_n", {31'b0, pad_oe_n}, 32'h1);
      chk("R1 pulls", {30'b0, scl_pull_o, sda_pull_o}, 32'h0);

      wr(A_PAD, 32'h0);
      chk("R11 pad enabled", {31'b0, pad_oe_n}, 32'h0);

      // R8 disabled requests ignored
      s0 = starts;
      wr(A_CMD, 32'h2);
      wr(A_DATA, 32'h55);
      repeat (20) @(negedge clk);
      rd(A_STAT, r); chk("R8 disabled status", r, 32'h0);
      chk("R8 disabled bus", {scl_line, sda_line, 30'(starts - s0)}, {2'b11, 30'd0});

      // R9 reserved operation
      wr(A_CMD, 32'h7);
      repeat (10) @(negedge clk);
      rd(A_STAT, r); chk("R9 error bit", r, 32'h04);
      chk("R9 no activity", {scl_line, sda_line, 30'(starts - s0)}, {2'b11, 30'd0});
      wr(A_STAT, 32'hFF);
      wr(A_CMD, 32'h1);

      // R8 request while busy rejected
      wr(A_TIM, 32'h1FF);
      s0 = starts;
      wr(A_CMD, 32'h3);
      wr(A_CMD, 32'h3);
      wait_done(n);
      rd(A_STAT, r); chk("R8 reject status", r, 32'h88);
      chk("R8 single start", 32'(starts - s0), 32'd1);
      // R7 write-one-to-clear
      wr(A_STAT, 32'h08);
      rd(A_STAT, r); chk("R7 partial clear", r, 32'h80);
      wr(A_STAT, 32'h80);
      rd(A_STAT, r); chk("R7 full clear", r, 32'h0);
      wr(A_CMD, 32'h1);
      wr(A_TIM, 32'h0);
      wr(A_CMD, 32'h5);
      wait_done(n);
      wr(A_CMD, 32'h1);

      // vector table
      for (int i = 0; i < NV; i++) begin
         {tim, kind, byt, nk} = VEC[i];
         len = phase_len(tim);
         tgt_nak = nk;
         wr(A_TIM, {23'b0, tim});
         wr(A_STAT, 32'hFF);
         s0 = starts; p0 = stops;
         case (kind)
            K_START:   wr(A_CMD, 32'h3);
            K_RESTART: wr(A_CMD, 32'hB);
            K_STOP:    wr(A_CMD, 32'h5);
            default:   wr(A_DATA, {24'b0, byt});
         endcase
         wait_done(n);
         chk($sformatf("R10 done edge vec%0d", i), n,
             (kind == K_BYTE) ? 36 * len + 1 : 4 * len + 1);
         case (kind)
            K_START:   chk("R2 start seen", 32'(starts - s0), 32'd1);
            K_RESTART: chk("R3 restart seen", 32'(starts - s0), 32'd1);
            K_STOP: begin
               chk("R4 stop seen", 32'(stops - p0), 32'd1);
               chk("R4 lines released", {30'b0, scl_line, sda_line}, 32'h3);
            end
            default: begin
               chk("R5 byte on bus", {24'b0, captured}, {24'b0, byt});
               rd(A_CMD, r); chk("R6 nak readback", {31'b0, r[3]}, {31'b0, nk});
               rd(A_STAT, r); chk("R7 status after byte", r, nk ? 32'h0B : 32'h0A);
            end
         endcase
         wr(A_CMD, 32'h1);
      end

      // R11 pad disabled keeps bus quiet
      wr(A_PAD, 32'h4);
      chk("R11 pad_oe_n high", {31'b0, pad_oe_n}, 32'h1);
      wr(A_CMD, 32'h5);
      quiet = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (scl_pull_o || sda_pull_o) quiet = 1'b0;
      end
      chk("R11 pulls off", {31'b0, quiet}, 32'h1);
      wait_done(n);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule